// File: doc/BRIEF.md
# Asymmetric-Delay Power-Fail Filter

This block cleans up the raw level from a supply-monitor comparator before the rest of the chip acts on it. The comparator output says only whether the monitored input is above its threshold. The comparator has no hysteresis of its own, so that level can chatter near the trip point. A single-event transient can also flip it for a short time. The filter turns the level into an active-low power-fail flag. The flag changes only after the raw level has disagreed with it on every clock edge for a qualification time.

The qualification time differs by direction. A recovery (flag going high) needs `RISE_CYC` consecutive disagreeing edges. A failure (flag going low) needs `FALL_CYC` such edges. Both are parameters counted in clock cycles. Any excursion shorter than the qualification time leaves the flag untouched, and the run count starts again from zero. A synchronous enable freezes the flag and discards any qualification in progress. A one-cycle strobe marks every filtered transition so that downstream logic can log it.

Top module: `pwrfail_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pf_n_o` is 0 (power fail indicated) and `chg_o` is 0.
- R2: With `pf_n_o` at 0 and `en_i` at 1, `pf_n_o` becomes 1 right after the `RISE_CYC`-th consecutive clock edge at which `above_i` is sampled as 1, and not before.
- R3: With `pf_n_o` at 1 and `en_i` at 1, `pf_n_o` becomes 0 right after the `FALL_CYC`-th consecutive clock edge at which `above_i` is sampled as 0, and not before.
- R4: An excursion of `above_i` away from `pf_n_o` that lasts fewer edges than the qualification time for that direction leaves `pf_n_o` unchanged. The next excursion must again last the full qualification time.
- R5: `chg_o` is 1 for exactly the one cycle in which `pf_n_o` holds a value different from the one it held in the previous cycle, and 0 otherwise.
- R6: At an edge where `en_i` is sampled as 0, `pf_n_o` keeps its value and any partial qualification is discarded. After `en_i` returns to 1, the full qualification time is needed again.
- R7: `pf_n_o` only ever moves to the level `above_i` had at the edge that caused the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_i | input | 1 | Raw comparator level, 1 when the monitored input is above threshold |
| en_i | input | 1 | Synchronous enable for qualification |
| pf_n_o | output | 1 | Filtered power-fail flag, 0 when the monitored input is below threshold |
| chg_o | output | 1 | One-cycle strobe on each filtered transition |

## Verification
The assertions take `above_i` and `en_i` to be synchronous to `clk`. The comparator level is expected to have been synchronised upstream, so the block contains no metastability stages and every edge samples a settled value. The bench drives both inputs only at the falling clock edge. It samples the outputs at the next falling edge. Random bursts of 1 to 30 cycles per level, plus brief enable drops, keep the run lengths on both sides of each qualification time without violating that assumption.

// File: rtl/pff_pkg.sv
package pff_pkg;

    // Registered output state of the flag stage.
    typedef struct packed {
        logic flag;
        logic strobe;
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{flag: 1'b0, strobe: 1'b0};

endpackage

// File: rtl/pff_qual_cnt.sv
module pff_qual_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             disagree_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             last_run;

    always_comb begin
        last_run = (cnt_q == (limit_i - CNT_W'(1)));
        done_o   = en_i && disagree_i && last_run;
        if (!en_i || !disagree_i || done_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit_i); // R4

    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/pff_flag_reg.sv
module pff_flag_reg
    import pff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flip_i,
    output logic flag_o,
    output logic strobe_o
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d.flag   = st_q.flag ^ flip_i;
        st_d.strobe = flip_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FLAG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o   = st_q.flag;
    assign strobe_o = st_q.strobe;

    AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o == (flag_o != $past(flag_o))); // R5

endmodule

// File: rtl/pwrfail_filter.sv
module pwrfail_filter #(
    parameter int RISE_CYC = 8,
    parameter int FALL_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_i,
    input  logic en_i,
    output logic pf_n_o,
    output logic chg_o
);

    localparam int MAX_CYC = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RISE_LIM = CNT_W'(RISE_CYC);
    localparam logic [CNT_W-1:0] FALL_LIM = CNT_W'(FALL_CYC);

    logic             disagree;
    logic [CNT_W-1:0] limit;
    logic             flip;
    logic             flag;
    logic             strobe;

    // A high flag qualifies a fall; a low flag qualifies a rise.
    always_comb begin
        disagree = (above_i != flag);
        limit    = flag ? FALL_LIM : RISE_LIM;
    end

    pff_qual_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .disagree_i (disagree),
        .limit_i    (limit),
        .done_o     (flip)
    );

    pff_flag_reg u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .flip_i   (flip),
        .flag_o   (flag),
        .strobe_o (strobe)
    );

    assign pf_n_o = flag;
    assign chg_o  = strobe;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(pf_n_o)); // R6

    AST_MOVES_TO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_n_o != $past(pf_n_o)) |-> (pf_n_o == $past(above_i))); // R7

    AST_NO_EARLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_n_o) |-> $past(en_i)); // R2

    AST_NO_EARLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pf_n_o) |-> $past(en_i)); // R3

endmodule

// File: tb/tb_pwrfail_filter.sv
module tb_pwrfail_filter;

    localparam int RISE_CYC = 8;
    localparam int FALL_CYC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_i = 1'b0;
    logic en_i = 1'b0;
    logic pf_n_o, chg_o;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state derived from the requirements.
    logic exp_flag = 1'b0;
    logic exp_chg  = 1'b0;
    int   run      = 0;

    always #10 clk = ~clk;

    pwrfail_filter #(
        .RISE_CYC (RISE_CYC),
        .FALL_CYC (FALL_CYC)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .above_i (above_i),
        .en_i    (en_i),
        .pf_n_o  (pf_n_o),
        .chg_o   (chg_o)
    );

    function automatic int need_for(input logic cur_flag);
        return cur_flag ? FALL_CYC : RISE_CYC;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, check at next falling edge.
    task automatic step(input logic a, input logic e, input string tag);
        above_i = a;
        en_i    = e;
        @(posedge clk);
        exp_chg = 1'b0;
        if (e && (a != exp_flag)) begin
            run++;
            if (run == need_for(exp_flag)) begin
                exp_flag = ~exp_flag;
                exp_chg  = 1'b1;
                run      = 0;
            end
        end else begin
            run = 0;
        end
        @(negedge clk);
        check(tag, pf_n_o, exp_flag, "pf_n_o");
        check("R5", chg_o, exp_chg, "chg_o");
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", pf_n_o, 1'b0, "pf_n_o in reset");
        check("R1", chg_o, 1'b0, "chg_o in reset");
        rst_n = 1'b1;
        step(1'b0, 1'b1, "R1");

        // R4: rise excursion one short, twice
        for (int i = 0; i < RISE_CYC - 1; i++) step(1'b1, 1'b1, "R4");
        step(1'b0, 1'b1, "R4");
        for (int i = 0; i < RISE_CYC - 1; i++) step(1'b1, 1'b1, "R4");
        step(1'b0, 1'b1, "R4");
        check("R4", pf_n_o, 1'b0, "after short rise");

        // R2: exact rise qualification
        for (int i = 0; i < RISE_CYC; i++) step(1'b1, 1'b1, "R2");
        check("R2", pf_n_o, 1'b1, "after full rise");

        // R4: fall excursion one short
        for (int i = 0; i < FALL_CYC - 1; i++) step(1'b0, 1'b1, "R4");
        step(1'b1, 1'b1, "R4");
        check("R4", pf_n_o, 1'b1, "after short fall");

        // R3: exact fall qualification
        for (int i = 0; i < FALL_CYC; i++) step(1'b0, 1'b1, "R3");
        check("R3", pf_n_o, 1'b0, "after full fall");

        // R6: enable drop discards partial rise
        for (int i = 0; i < RISE_CYC - 1; i++) step(1'b1, 1'b1, "R6");
        step(1'b1, 1'b0, "R6");
        for (int i = 0; i < RISE_CYC - 1; i++) step(1'b1, 1'b1, "R6");
        check("R6", pf_n_o, 1'b0, "partial run after enable drop");
        step(1'b1, 1'b1, "R6");
        check("R6", pf_n_o, 1'b1, "full run after enable drop");

        // R7 and mixed: random bursts
        for (int b = 0; b < 400; b++) begin
            logic lvl;
            int   len;
            lvl = 1'($urandom_range(0, 1));
            len = $urandom_range(1, 30);
            for (int k = 0; k < len; k++) begin
                step(lvl, ($urandom_range(0, 15) != 0), "R7");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule